// File: doc/BRIEF.md
# PHY Discovery and Configuration Sequencer

After reset, this block walks the 32 management addresses of an MDIO bus and tests each one for an attached PHY. It reads the PHY's status register and applies a fixed bit-pattern test. For every PHY that passes, the block does the following:

- It reads the control and advertisement registers.
- It chooses the advertisement word to use.
- It rewrites the advertisement only when the chosen word differs from the one it read.
- It rebuilds the control word from the autonegotiate/forced, duplex and speed settings.

The block does not drive the serial bus itself. It issues one register transaction at a time to an MDIO master through a request/done handshake.

The addresses of the PHYs it finds are stored, in the order they were found, in a table of `MAX_PHYS` slots. The table and the number of entries are visible on the ports, and a one-cycle pulse marks the end of the scan. When a control rewrite flips the autonegotiation enable bit, the word is written twice, with a settle wait of `SETTLE_US` microseconds between the two writes. The length of the wait is derived from `CLK_HZ`.

The state machine has these states:

- **START** is the reset state. It goes to PROBE.
- **PROBE** reads status. When done arrives it goes to RD_CTRL if a PHY is present, else to ADVANCE.
- **RD_CTRL** reads control, then goes to RD_ADV.
- **RD_ADV** reads the advertisement, then goes to DECIDE.
- **DECIDE** picks the advertisement and records the slot. It goes to WR_ADV if the picked word differs from the read one, else to CTRL_CHK.
- **WR_ADV** writes the advertisement, then goes to CTRL_CHK.
- **CTRL_CHK** goes to ADVANCE if the control word is unchanged. It goes to WR_CTRL_A if the enable bit toggled, else to WR_CTRL_B.
- **WR_CTRL_A** writes control, then goes to SETTLE.
- **SETTLE** counts out the wait, then goes to WR_CTRL_B.
- **WR_CTRL_B** writes control, then goes to ADVANCE.
- **ADVANCE** goes to FINISH when the last address has been probed or the table is full. Otherwise it goes to PROBE at the next address.
- **FINISH** pulses done, then goes to HALT.
- **HALT** holds until the next reset.

Top module: `phy_scan_seq`

## Requirements
- R1: Probes use register 1 (status) at addresses 1, 2, … 31 and then 0, in that order, one transaction at a time. The request and its address, register and direction stay stable until `mdio_done_i` is seen.
- R2: An address holds a PHY when (status AND 0x8301) equals 0x8001, or when status bit 9 is 0 and (status AND 0x7800) is nonzero. Otherwise only the status read is made at that address.
- R3: For a present PHY, register 0 and then register 4 are read. If bits 8..5 of the advertisement read are all zero, the working advertisement becomes ((status >> 6) AND 0x03E0) OR 1.
- R4: The advertisement to apply is chosen in this order:
  1. The global value, which is `cfg_adv_i` when it is nonzero, else a learned value.
  2. The slot's `slot_adv_i[16*k +: 16]` when nonzero.
  3. The working advertisement, which is then also stored as the learned value.

  Register 4 is written only when the chosen value differs from the working advertisement.
- R5: With `cfg_autoneg_i`=1, bit 12 is set, and bit 9 is also set if setting bit 12 changed the word. With `cfg_autoneg_i`=0, bit 12 is cleared. Bits 15, 14, 13, 11, 10, 8 and 7 are then cleared. Bit 8 is then set from `cfg_full_duplex_i` and bit 13 from `cfg_speed100_i`.
- R6: Register 0 is written only if the new word differs from the one read. If bit 12 changed, the word is written twice, and the second request starts at least SETTLE_US·CLK_HZ/10^6 cycles after the first completes.
- R7: Found addresses fill `phy_table_o` slot 0 upward, 5 bits per slot with slot k at bits [5k+4:5k]. `found_count_o` gives the number of entries. Once `MAX_PHYS` are found, no further address is probed.
- R8: When no PHY is found and `cfg_phy_required_i`=1, slot 0 reads 1 while the count stays 0. When no PHY is found and the input is 0, slot 0 stays 0.
- R9: `scan_done_o` pulses for exactly one cycle after the last transaction completes. No further request is made until the next reset.
- R10: During reset, `mdio_req_o`, `scan_done_o`, `found_count_o` and `phy_table_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the scan starts when it is released |
| cfg_autoneg_i | input | 1 | 1 = autonegotiate, 0 = forced media |
| cfg_full_duplex_i | input | 1 | Duplex bit placed in the new control word |
| cfg_speed100_i | input | 1 | Speed-100 bit placed in the new control word |
| cfg_phy_required_i | input | 1 | Report address 1 in slot 0 when nothing is found |
| cfg_adv_i | input | 16 | Global advertisement; 0 means unset |
| slot_adv_i | input | 16·MAX_PHYS | Per-slot stored advertisements; 0 means unset |
| mdio_req_o | output | 1 | Transaction request, held until done |
| mdio_we_o | output | 1 | 1 = write, 0 = read |
| mdio_phy_o | output | 5 | PHY address |
| mdio_reg_o | output | 5 | Register number |
| mdio_wdata_o | output | 16 | Write data |
| mdio_done_i | input | 1 | One-cycle completion from the MDIO master |
| mdio_rdata_i | input | 16 | Read data, valid with done |
| found_count_o | output | clog2(MAX_PHYS+1) | Number of PHYs found |
| phy_table_o | output | 5·MAX_PHYS | Found addresses, slot k at [5k+4:5k] |
| scan_done_o | output | 1 | One-cycle end-of-scan pulse |

## Verification
A wrong state or counter here almost always surfaces at the MDIO request port within one transaction. Typical symptoms are:

- a probe at the wrong address;
- a missing or extra read of registers 0 and 4;
- a write of the wrong value;
- a second control write issued before the settle window ends.

A scoreboard holds the expected transaction stream, so such a fault is caught on the first request that differs. Faults in slot bookkeeping are caught by comparing the table and count when `scan_done_o` rises. A misplaced end condition shows up either as extra probes or as a queue left non-empty at that point.

// File: rtl/phy_scan_pkg.sv
package phy_scan_pkg;

    localparam logic [4:0] REG_CTRL = 5'd0;
    localparam logic [4:0] REG_STAT = 5'd1;
    localparam logic [4:0] REG_ADV  = 5'd4;

    localparam logic [15:0] PRES_MASK  = 16'h8301;
    localparam logic [15:0] PRES_MATCH = 16'h8001;
    localparam logic [15:0] CAP_MASK   = 16'h7800;
    localparam int          T4_BIT     = 9;

    localparam logic [15:0] ADV_ABILITY = 16'h01E0;
    localparam logic [15:0] ADV_BUILD   = 16'h03E0;

    localparam logic [15:0] CTL_AN_EN   = 16'h1000;
    localparam logic [15:0] CTL_AN_RST  = 16'h0200;
    localparam logic [15:0] CTL_FDX     = 16'h0100;
    localparam logic [15:0] CTL_SPD100  = 16'h2000;
    localparam logic [15:0] CTL_CLEAR   = 16'hED80;

    localparam logic [4:0] DEFAULT_ADDR = 5'd1;

    typedef enum logic [3:0] {
        S_START,
        S_PROBE,
        S_RD_CTRL,
        S_RD_ADV,
        S_DECIDE,
        S_WR_ADV,
        S_CTRL_CHK,
        S_WR_CTRL_A,
        S_SETTLE,
        S_WR_CTRL_B,
        S_ADVANCE,
        S_FINISH,
        S_HALT
    } scan_state_e;

endpackage

// File: rtl/phy_scan_eval.sv
module phy_scan_eval
    import phy_scan_pkg::*;
(
    input  logic [15:0] status_i,
    input  logic [15:0] adv_i,
    output logic        present_o,
    output logic [15:0] adv_o
);

    logic pattern_hit;
    logic capability_hit;

    always_comb begin
        pattern_hit    = ((status_i & PRES_MASK) == PRES_MATCH);
        capability_hit = !status_i[T4_BIT] && ((status_i & CAP_MASK) != 16'h0000);
        present_o      = pattern_hit || capability_hit;
        if ((adv_i & ADV_ABILITY) == 16'h0000) begin
            adv_o = ((status_i >> 6) & ADV_BUILD) | 16'h0001;
        end else begin
            adv_o = adv_i;
        end
    end

endmodule

// File: rtl/phy_scan_ctrl_calc.sv
module phy_scan_ctrl_calc
    import phy_scan_pkg::*;
(
    input  logic [15:0] ctrl_old_i,
    input  logic        autoneg_i,
    input  logic        full_duplex_i,
    input  logic        speed100_i,
    output logic [15:0] ctrl_new_o,
    output logic        an_toggle_o,
    output logic        dirty_o
);

    logic [15:0] staged;

    always_comb begin
        staged      = ctrl_old_i;
        an_toggle_o = 1'b0;
        if (autoneg_i) begin
            staged = staged | CTL_AN_EN;
            if (staged != ctrl_old_i) begin
                an_toggle_o = 1'b1;
                staged      = staged | CTL_AN_RST;
            end
        end else begin
            staged = staged & ~CTL_AN_EN;
            if (staged != ctrl_old_i) begin
                an_toggle_o = 1'b1;
            end
        end
        staged = staged & ~CTL_CLEAR;
        if (full_duplex_i) begin
            staged = staged | CTL_FDX;
        end
        if (speed100_i) begin
            staged = staged | CTL_SPD100;
        end
        ctrl_new_o = staged;
        dirty_o    = (staged != ctrl_old_i);
    end

endmodule

// File: rtl/phy_scan_table.sv
module phy_scan_table
    import phy_scan_pkg::*;
#(
    parameter int MAX_PHYS = 4,
    parameter int IW       = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [IW-1:0]         wr_idx_i,
    input  logic [4:0]            wr_addr_i,
    input  logic                  set_dflt_i,
    output logic [MAX_PHYS*5-1:0] table_o
);

    for (genvar g = 0; g < MAX_PHYS; g++) begin : g_slot
        logic [4:0] entry_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry_q <= 5'd0;
            end else if (wr_en_i && (wr_idx_i == IW'(g))) begin
                entry_q <= wr_addr_i;
            end else if ((g == 0) && set_dflt_i) begin
                entry_q <= DEFAULT_ADDR;
            end
        end

        assign table_o[g*5 +: 5] = entry_q;
    end

    // R7: a slot write never targets a slot beyond the table
    a_r7_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> (int'(wr_idx_i) < MAX_PHYS));

endmodule

// File: rtl/phy_scan_seq.sv
module phy_scan_seq
    import phy_scan_pkg::*;
#(
    parameter int MAX_PHYS  = 4,
    parameter int CLK_HZ    = 100_000_000,
    parameter int SETTLE_US = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_autoneg_i,
    input  logic                          cfg_full_duplex_i,
    input  logic                          cfg_speed100_i,
    input  logic                          cfg_phy_required_i,
    input  logic [15:0]                   cfg_adv_i,
    input  logic [MAX_PHYS*16-1:0]        slot_adv_i,
    output logic                          mdio_req_o,
    output logic                          mdio_we_o,
    output logic [4:0]                    mdio_phy_o,
    output logic [4:0]                    mdio_reg_o,
    output logic [15:0]                   mdio_wdata_o,
    input  logic                          mdio_done_i,
    input  logic [15:0]                   mdio_rdata_i,
    output logic [$clog2(MAX_PHYS+1)-1:0] found_count_o,
    output logic [MAX_PHYS*5-1:0]         phy_table_o,
    output logic                          scan_done_o
);

    localparam int CW       = $clog2(MAX_PHYS + 1);
    localparam int IW       = (MAX_PHYS > 1) ? $clog2(MAX_PHYS) : 1;
    localparam int RAW_WAIT = (CLK_HZ / 1_000_000) * SETTLE_US;
    localparam int WAIT_CYC = (RAW_WAIT < 1) ? 1 : RAW_WAIT;
    localparam int TW       = $clog2(WAIT_CYC + 1);
    localparam logic [5:0] LAST_PROBE = 6'd32;

    scan_state_e state_q, state_d;

    logic [5:0]    probe_q;
    logic [CW-1:0] found_q;
    logic [15:0]   stat_q;
    logic [15:0]   ctrl_q;
    logic [15:0]   adv_q;
    logic [15:0]   to_adv_q;
    logic [15:0]   learned_q;
    logic [TW-1:0] settle_q;

    logic [15:0] eval_status;
    logic        present;
    logic [15:0] adv_work;
    logic [15:0] ctrl_new;
    logic        an_toggle;
    logic        ctrl_dirty;
    logic [15:0] glob_val;
    logic [15:0] slot_val;
    logic [15:0] pick_adv;
    logic        learn_now;
    logic [IW-1:0] slot_idx;
    logic        scan_over;

    // ------------------------------------------------------------------
    // Evaluation helpers
    // ------------------------------------------------------------------
    assign eval_status = (state_q == S_PROBE) ? mdio_rdata_i : stat_q;

    phy_scan_eval u_eval (
        .status_i  (eval_status),
        .adv_i     (mdio_rdata_i),
        .present_o (present),
        .adv_o     (adv_work)
    );

    phy_scan_ctrl_calc u_ctrl (
        .ctrl_old_i    (ctrl_q),
        .autoneg_i     (cfg_autoneg_i),
        .full_duplex_i (cfg_full_duplex_i),
        .speed100_i    (cfg_speed100_i),
        .ctrl_new_o    (ctrl_new),
        .an_toggle_o   (an_toggle),
        .dirty_o       (ctrl_dirty)
    );

    assign slot_idx = found_q[IW-1:0];

    always_comb begin
        glob_val  = (cfg_adv_i != 16'h0000) ? cfg_adv_i : learned_q;
        slot_val  = slot_adv_i[slot_idx*16 +: 16];
        learn_now = 1'b0;
        if (glob_val != 16'h0000) begin
            pick_adv = glob_val;
        end else if (slot_val != 16'h0000) begin
            pick_adv = slot_val;
        end else begin
            pick_adv  = adv_q;
            learn_now = 1'b1;
        end
    end

    assign scan_over = (probe_q == LAST_PROBE) || (found_q == CW'(MAX_PHYS));

    // ------------------------------------------------------------------
    // State register
    // ------------------------------------------------------------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_START;
        end else begin
            state_q <= state_d;
        end
    end

    // ------------------------------------------------------------------
    // Next-state logic
    // ------------------------------------------------------------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_START:     state_d = S_PROBE;
            S_PROBE:     if (mdio_done_i) state_d = present ? S_RD_CTRL : S_ADVANCE;
            S_RD_CTRL:   if (mdio_done_i) state_d = S_RD_ADV;
            S_RD_ADV:    if (mdio_done_i) state_d = S_DECIDE;
            S_DECIDE:    state_d = (pick_adv != adv_q) ? S_WR_ADV : S_CTRL_CHK;
            S_WR_ADV:    if (mdio_done_i) state_d = S_CTRL_CHK;
            S_CTRL_CHK: begin
                if (!ctrl_dirty) begin
                    state_d = S_ADVANCE;
                end else begin
                    state_d = an_toggle ? S_WR_CTRL_A : S_WR_CTRL_B;
                end
            end
            S_WR_CTRL_A: if (mdio_done_i) state_d = S_SETTLE;
            S_SETTLE:    if (settle_q == TW'(WAIT_CYC - 1)) state_d = S_WR_CTRL_B;
            S_WR_CTRL_B: if (mdio_done_i) state_d = S_ADVANCE;
            S_ADVANCE:   state_d = scan_over ? S_FINISH : S_PROBE;
            S_FINISH:    state_d = S_HALT;
            S_HALT:      state_d = S_HALT;
            default:     state_d = S_HALT;
        endcase
    end

    // ------------------------------------------------------------------
    // Datapath registers
    // ------------------------------------------------------------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            probe_q   <= 6'd1;
            found_q   <= '0;
            stat_q    <= '0;
            ctrl_q    <= '0;
            adv_q     <= '0;
            to_adv_q  <= '0;
            learned_q <= '0;
            settle_q  <= '0;
        end else begin
            if ((state_q == S_PROBE) && mdio_done_i) begin
                stat_q <= mdio_rdata_i;
            end
            if ((state_q == S_RD_CTRL) && mdio_done_i) begin
                ctrl_q <= mdio_rdata_i;
            end
            if ((state_q == S_RD_ADV) && mdio_done_i) begin
                adv_q <= adv_work;
            end
            if (state_q == S_DECIDE) begin
                to_adv_q <= pick_adv;
                found_q  <= found_q + 1'b1;
                if (learn_now) begin
                    learned_q <= adv_q;
                end
            end
            if (state_q == S_SETTLE) begin
                settle_q <= settle_q + 1'b1;
            end else begin
                settle_q <= '0;
            end
            if ((state_q == S_ADVANCE) && !scan_over) begin
                probe_q <= probe_q + 1'b1;
            end
        end
    end

    phy_scan_table #(
        .MAX_PHYS (MAX_PHYS),
        .IW       (IW)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (state_q == S_DECIDE),
        .wr_idx_i   (slot_idx),
        .wr_addr_i  (probe_q[4:0]),
        .set_dflt_i ((state_q == S_FINISH) && (found_q == '0) && cfg_phy_required_i),
        .table_o    (phy_table_o)
    );

    // ------------------------------------------------------------------
    // Outputs
    // ------------------------------------------------------------------
    always_comb begin
        mdio_req_o   = 1'b0;
        mdio_we_o    = 1'b0;
        mdio_reg_o   = REG_STAT;
        mdio_wdata_o = 16'h0000;
        unique case (state_q)
            S_PROBE: begin
                mdio_req_o = 1'b1;
                mdio_reg_o = REG_STAT;
            end
            S_RD_CTRL: begin
                mdio_req_o = 1'b1;
                mdio_reg_o = REG_CTRL;
            end
            S_RD_ADV: begin
                mdio_req_o = 1'b1;
                mdio_reg_o = REG_ADV;
            end
            S_WR_ADV: begin
                mdio_req_o   = 1'b1;
                mdio_we_o    = 1'b1;
                mdio_reg_o   = REG_ADV;
                mdio_wdata_o = to_adv_q;
            end
            S_WR_CTRL_A, S_WR_CTRL_B: begin
                mdio_req_o   = 1'b1;
                mdio_we_o    = 1'b1;
                mdio_reg_o   = REG_CTRL;
                mdio_wdata_o = ctrl_new;
            end
            default: begin
                mdio_req_o = 1'b0;
            end
        endcase
    end

    assign mdio_phy_o    = probe_q[4:0];
    assign found_count_o = found_q;
    assign scan_done_o   = (state_q == S_FINISH);

    // ------------------------------------------------------------------
    // Assertions
    // ------------------------------------------------------------------
    logic done_seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_seen_q <= 1'b0;
        end else if (scan_done_o) begin
            done_seen_q <= 1'b1;
        end
    end

    // R1: an open request holds its command until completion
    a_r1_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_req_o && !mdio_done_i) |=> (mdio_req_o && $stable(mdio_phy_o)
            && $stable(mdio_reg_o) && $stable(mdio_we_o) && $stable(mdio_wdata_o)));

    // R3: reads only touch control, status or advertisement
    a_r3_read_target: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_req_o && !mdio_we_o) |-> (mdio_reg_o == REG_CTRL || mdio_reg_o == REG_STAT
            || mdio_reg_o == REG_ADV));

    // R4: writes only touch control or advertisement
    a_r4_write_target: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_req_o && mdio_we_o) |-> (mdio_reg_o == REG_CTRL || mdio_reg_o == REG_ADV));

    // R7: the count never exceeds the table size
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(found_count_o) <= MAX_PHYS);

    // R9: the end pulse lasts one cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done_o |=> !scan_done_o);

    // R9: the bus stays quiet after the scan ends
    a_r9_quiet_after: assert property (@(posedge clk) disable iff (!rst_n)
        done_seen_q |-> !mdio_req_o);

endmodule

// File: tb/phy_scan_seq_tb_top.sv
module phy_scan_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int MAXP       = 4;
    localparam int CLK_HZ     = 2_000_000;
    localparam int SETTLE_US  = 10;
    localparam int WAIT_CYC   = 20;
    localparam int LAT        = 3;
    localparam int CW         = $clog2(MAXP + 1);

    typedef struct packed {
        logic        we;
        logic [4:0]  phy;
        logic [4:0]  rg;
        logic [15:0] wdata;
        logic        gap;
    } xact_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_an = 1'b1, cfg_fd = 1'b0, cfg_sp = 1'b0, cfg_req = 1'b0;
    logic [15:0] cfg_adv = 16'h0;
    logic [MAXP*16-1:0] slot_adv = '0;
    logic mdio_req, mdio_we, mdio_done = 1'b0, scan_done;
    logic [4:0] mdio_phy, mdio_reg;
    logic [15:0] mdio_wdata, mdio_rdata = 16'h0;
    logic [CW-1:0] found_count;
    logic [MAXP*5-1:0] phy_table;

    xact_t exp_q[$];
    logic [15:0] m_stat[32];
    logic [15:0] m_ctrl[32];
    logic [15:0] m_adv[32];
    int exp_count;
    logic [4:0] exp_tab[MAXP];
    int n_checks = 0, n_fail = 0;
    int cyc = 0, last_ctrl_done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    phy_scan_seq #(.MAX_PHYS(MAXP), .CLK_HZ(CLK_HZ), .SETTLE_US(SETTLE_US)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_autoneg_i(cfg_an), .cfg_full_duplex_i(cfg_fd), .cfg_speed100_i(cfg_sp),
        .cfg_phy_required_i(cfg_req), .cfg_adv_i(cfg_adv), .slot_adv_i(slot_adv),
        .mdio_req_o(mdio_req), .mdio_we_o(mdio_we), .mdio_phy_o(mdio_phy),
        .mdio_reg_o(mdio_reg), .mdio_wdata_o(mdio_wdata), .mdio_done_i(mdio_done),
        .mdio_rdata_i(mdio_rdata), .found_count_o(found_count),
        .phy_table_o(phy_table), .scan_done_o(scan_done));

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, expv);
        end
    endtask

    // Spec model of the control word (R5)
    function automatic logic [15:0] model_ctrl(input logic [15:0] old, input bit an,
                                               input bit fd, input bit sp, output bit tog);
        logic [15:0] w;
        w = old;
        if (an) begin
            w = w | 16'h1000;
            tog = (w != old);
            if (tog) w = w | 16'h0200;
        end else begin
            w = w & ~16'h1000;
            tog = (w != old);
        end
        w = w & ~16'hED80;
        if (fd) w = w | 16'h0100;
        if (sp) w = w | 16'h2000;
        return w;
    endfunction

    task automatic clear_phys();
        for (int i = 0; i < 32; i++) begin
            m_stat[i] = 16'hFFFF;
            m_ctrl[i] = 16'h0000;
            m_adv[i]  = 16'h0000;
        end
    endtask

    // Driver side of the scoreboard: push the expected transaction stream
    task automatic build_expect();
        int found;
        logic [15:0] learned;
        found   = 0;
        learned = 16'h0;
        exp_q.delete();
        for (int i = 0; i < MAXP; i++) exp_tab[i] = 5'd0;
        for (int a = 1; a <= 32; a++) begin
            logic [4:0]  ad;
            logic [15:0] st, wadv, glob, slot, to, nc;
            bit pres, tog;
            if (found == MAXP) break;
            ad = a[4:0];
            st = m_stat[ad];
            exp_q.push_back('{we:1'b0, phy:ad, rg:5'd1, wdata:16'h0, gap:1'b0});
            pres = ((st & 16'h8301) == 16'h8001) || (!st[9] && ((st & 16'h7800) != 0));
            if (pres) begin
                exp_q.push_back('{we:1'b0, phy:ad, rg:5'd0, wdata:16'h0, gap:1'b0});
                exp_q.push_back('{we:1'b0, phy:ad, rg:5'd4, wdata:16'h0, gap:1'b0});
                wadv = m_adv[ad];
                if ((wadv & 16'h01E0) == 0) wadv = ((st >> 6) & 16'h03E0) | 16'h0001;
                glob = (cfg_adv != 0) ? cfg_adv : learned;
                slot = slot_adv[found*16 +: 16];
                if (glob != 0) to = glob;
                else if (slot != 0) to = slot;
                else begin
                    to = wadv;
                    learned = wadv;
                end
                if (to != wadv)
                    exp_q.push_back('{we:1'b1, phy:ad, rg:5'd4, wdata:to, gap:1'b0});
                nc = model_ctrl(m_ctrl[ad], cfg_an, cfg_fd, cfg_sp, tog);
                if (nc != m_ctrl[ad]) begin
                    if (tog) exp_q.push_back('{we:1'b1, phy:ad, rg:5'd0, wdata:nc, gap:1'b0});
                    exp_q.push_back('{we:1'b1, phy:ad, rg:5'd0, wdata:nc, gap:tog});
                end
                exp_tab[found] = ad;
                found++;
            end
        end
        exp_count = found;
        if (found == 0 && cfg_req) exp_tab[0] = 5'd1;
    endtask

    // Monitor side: MDIO responder that pops and compares each request
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mdio_req) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected request",
                          {mdio_we, mdio_phy, mdio_reg, 5'd0, 16'h0}, 32'h0);
                end else begin
                    xact_t e;
                    string rq;
                    e  = exp_q.pop_front();
                    rq = (e.rg == 5'd1) ? "R1" : (!e.we ? "R3" : (e.rg == 5'd4 ? "R4" : "R5"));
                    check({mdio_we, mdio_phy, mdio_reg} == {e.we, e.phy, e.rg}, rq,
                          "command we/phy/reg", {21'h0, mdio_we, mdio_phy, mdio_reg},
                          {21'h0, e.we, e.phy, e.rg});
                    if (e.we)
                        check(mdio_wdata == e.wdata, rq, "write data", {16'h0, mdio_wdata},
                              {16'h0, e.wdata});
                    if (e.gap)
                        check((cyc - last_ctrl_done) >= WAIT_CYC, "R6", "settle gap",
                              cyc - last_ctrl_done, WAIT_CYC);
                end
                repeat (LAT) @(negedge clk);
                case (mdio_reg)
                    5'd0:    mdio_rdata = m_ctrl[mdio_phy];
                    5'd1:    mdio_rdata = m_stat[mdio_phy];
                    5'd4:    mdio_rdata = m_adv[mdio_phy];
                    default: mdio_rdata = 16'hFFFF;
                endcase
                if (mdio_we && mdio_reg == 5'd0) last_ctrl_done = cyc;
                mdio_done = 1'b1;
                @(negedge clk);
                mdio_done = 1'b0;
            end
        end
    end

    task automatic run_scan(input string cnt_req);
        bit seen, quiet;
        rst_n = 1'b0;
        build_expect();
        repeat (3) @(negedge clk);
        check(!mdio_req && !scan_done && found_count == 0 && phy_table == 0, "R10",
              "reset outputs", {mdio_req, scan_done, found_count}, 32'h0);
        rst_n = 1'b1;
        seen = 1'b0;
        for (int t = 0; t < 6000; t++) begin
            @(negedge clk);
            if (scan_done) begin
                seen = 1'b1;
                break;
            end
        end
        check(seen, "R9", "done pulse seen", seen, 1);
        check(exp_q.size() == 0, "R7", "expected transactions left", exp_q.size(), 0);
        @(negedge clk);
        check(int'(found_count) == exp_count, cnt_req, "found count", found_count, exp_count);
        for (int i = 0; i < MAXP; i++)
            check(phy_table[i*5 +: 5] == exp_tab[i], (exp_count == 0) ? "R8" : "R7",
                  $sformatf("table slot %0d", i), phy_table[i*5 +: 5], exp_tab[i]);
        quiet = 1'b1;
        repeat (30) begin
            @(negedge clk);
            if (scan_done || mdio_req) quiet = 1'b0;
        end
        check(quiet, "R9", "quiet after done", quiet, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        // No PHYs, one required (R8)
        clear_phys();
        cfg_req = 1'b1;
        run_scan("R8");

        // No PHYs, none required (R8)
        clear_phys();
        cfg_req = 1'b0;
        run_scan("R8");

        // Presence patterns, address wrap, built and learned advertisement (R2, R3, R4, R6)
        clear_phys();
        cfg_an = 1'b1; cfg_fd = 1'b0; cfg_sp = 1'b0; cfg_adv = 16'h0; slot_adv = '0;
        m_stat[3] = 16'h7809; m_ctrl[3] = 16'h3100; m_adv[3] = 16'h0001;
        m_stat[5] = 16'h8201;
        m_stat[7] = 16'h0000;
        m_stat[0] = 16'h8001; m_ctrl[0] = 16'h0000; m_adv[0] = 16'h05E1;
        run_scan("R2");

        // Forced mode, global advertisement, table fills early (R5, R6, R7)
        clear_phys();
        cfg_an = 1'b0; cfg_fd = 1'b1; cfg_sp = 1'b1; cfg_adv = 16'h01E1;
        m_stat[2]  = 16'h786D; m_ctrl[2]  = 16'h1000; m_adv[2]  = 16'h01E1;
        m_stat[5]  = 16'h786D; m_ctrl[5]  = 16'h2100; m_adv[5]  = 16'h0061;
        m_stat[7]  = 16'h786D; m_ctrl[7]  = 16'h0800; m_adv[7]  = 16'h01E1;
        m_stat[9]  = 16'h8001; m_ctrl[9]  = 16'h3300; m_adv[9]  = 16'h0000;
        m_stat[11] = 16'h786D; m_ctrl[11] = 16'h0000; m_adv[11] = 16'h0001;
        run_scan("R7");

        // Slot values versus learned value (R4)
        clear_phys();
        cfg_an = 1'b1; cfg_fd = 1'b1; cfg_sp = 1'b0; cfg_adv = 16'h0;
        slot_adv = {16'h0, 16'h0021, 16'h0000, 16'h0141};
        m_stat[1] = 16'h7849; m_ctrl[1] = 16'h1100; m_adv[1] = 16'h01E1;
        m_stat[4] = 16'h7849; m_ctrl[4] = 16'h1000; m_adv[4] = 16'h00A1;
        m_stat[6] = 16'h7849; m_ctrl[6] = 16'h0400; m_adv[6] = 16'h0021;
        run_scan("R4");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule